// File: doc/BRIEF.md
# Nibble Accumulator Execution Core

This block executes a compact instruction subset for a 4-bit controller. Its state is a 4-bit accumulator, a pair of 4-bit pointer registers (high and low half) that together form an 8-bit data-memory address, a carry flag, a zero flag, a status flag, and a table pointer into a byte-wide lookup table. The table holds two nibbles per entry. The data memory is an internal array of 256 nibbles. The core supports immediate loads, direct and pointer-indirect moves, nibble reads from the table, rotates through carry, adds and increments/decrements.

Instruction bytes arrive one per clock on `instrByte` while `instrValid` is high. A byte with `instrValid` low is not consumed. A two-byte instruction takes two consumed bytes. It takes effect on the clock edge that consumes its second byte. Every other instruction takes effect on the edge that consumes it. The table is read combinationally: the core drives `tableAddr` from its table pointer, and the surrounding logic returns the entry on `tableData`.

Top module: `nib_core`

## Requirements
- R1: A single byte `1101 kkkk` loads k into the accumulator and sets zero to (k==0). `1001 kkkk` loads k into the high pointer. `1000 kkkk` loads k into the low pointer. The pointer loads leave the flags unchanged.
- R2: `0110 1010, a` loads the accumulator from memory word a and sets zero from the loaded value. `0110 1001, a` writes the accumulator to word a and leaves the flags unchanged.
- R3: `0101 1010` loads the accumulator from memory word {high,low} and sets zero from the loaded value. `0101 1001` writes the accumulator to that word.
- R4: `0111 1111` stores the accumulator to {high,low} and then increments the low pointer modulo 16. `0111 1101` does the same store and then decrements the low pointer modulo 16. `1010 kkkk` stores k to {high,low} and then increments the low pointer. None of these changes the high pointer or the flags.
- R5: `0100 1000, kkkk yyyy` writes k to memory word y, where y is in the range 0 to 15. `0100 1110, a` loads the low pointer from word (a with bit 0 cleared) and the high pointer from word (a with bit 0 set). Neither changes the flags.
- R6: `0110 0101` loads bits [3:0] of the table entry at the table pointer into the accumulator. `0110 0111` loads bits [7:4] of that entry into the accumulator and then increments the table pointer. Both set zero from the loaded value.
- R7: `0111 0110` copies the high pointer into the accumulator. `0111 0100` copies the low pointer into the accumulator. Both set zero from the copied value.
- R8: `0101 0000` rotates {carry,accumulator} left, so the old bit 3 goes to carry and the old carry goes to bit 0. `0101 0001` rotates right, so the old bit 0 goes to carry and the old carry goes to bit 3. Both set zero from the new accumulator.
- R9: The following instructions write a 4-bit sum to the accumulator: `0111 0000` (acc+mem[{high,low}]+carry), `0111 0001` (acc+mem[{high,low}]), `0110 1110, 0101 kkkk` (acc+k) and `0101 1110` (acc+1). Each sets carry to the carry out, zero to (sum==0) and status to the complement of the carry out.
- R10: The following instructions write a 4-bit sum to a destination other than the accumulator: `0110 1110, 1001 kkkk` (high+k), `0110 1110, 0001 kkkk` (low+k), `0110 1110, 1101 kkkk` (mem[{high,low}]+k) and `0100 1001, kkkk yyyy` (mem[y]+k). Each sets zero from the sum and status to the complement of the carry out. Carry is unchanged.
- R11: `0101 1100` decrements the accumulator, `0111 1100` decrements the low pointer, and `0101 1101` decrements mem[{high,low}]. Each decrement is computed as x+15. Each sets zero from the result and status to (x==0), which is the complement of the carry out. Only the accumulator decrement also writes carry.
- R12: Any other byte executes as a no-op. Under prefix `0110 1110`, any second byte outside the four listed forms is also a no-op. Bytes with `instrValid` low change nothing, and they may fall between the two bytes of an instruction. No state changes after the first byte of a two-byte instruction.
- R13: Reset clears the accumulator, both pointers, the table pointer and all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction byte present this cycle |
| instrByte | input | 8 | Instruction byte |
| tableData | input | 8 | Table entry at `tableAddr` |
| tableAddr | output | DP_W | Table pointer |
| acc | output | 4 | Accumulator |
| ptrHi | output | 4 | High pointer register |
| ptrLo | output | 4 | Low pointer register |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |
| status | output | 1 | Status flag |

## Verification
Random opcodes, operands and memory addresses run against a bench model. The operand values are unconstrained, so carry-in and carry-out combinations occur that expose any mix-up between carry, zero and status, or between which operations update carry and which do not. Directed sequences cover the edge cases. They wrap the low pointer in both directions without touching the high pointer. They increment and decrement across 0/15 to test carry and status together. They split a two-byte instruction with idle cycles whose byte looks like an instruction, which separates correct byte consumption from sampling whenever `instrValid` is low. They also send undefined single bytes and undefined second bytes, which must leave every register unchanged.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int DATA_W = 4;
  localparam int ADDR_W = 2 * DATA_W;

  typedef enum logic [4:0] {
    OP_NOP, OP_LDA, OP_LDAM, OP_LDAX, OP_LDAXI, OP_LDH, OP_LDHL, OP_LDIA,
    OP_LDL, OP_STA, OP_STAM, OP_STAMD, OP_STAMI, OP_STD, OP_STDMI, OP_THA,
    OP_TLA, OP_RLCA, OP_RRCA, OP_ADCAM, OP_ADDY, OP_ADDA, OP_ADDAM, OP_ADDH,
    OP_ADDL, OP_ADDM, OP_DECA, OP_DECL, OP_DECM, OP_INCA
  } opKind_e;

  typedef struct packed {
    logic              fire;
    opKind_e           op;
    logic [DATA_W-1:0] imm;
    logic [ADDR_W-1:0] addr;
  } ctrlStrobe_t;
endpackage

// File: rtl/nib_ctrl.sv
module nib_ctrl
  import nib_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [7:0]  instrByte,
  output ctrlStrobe_t strb
);
  logic       pending;
  logic [7:0] prefix;

  function automatic logic isPrefix(input logic [7:0] b);
    return (b == 8'h6A) || (b == 8'h69) || (b == 8'h48) ||
           (b == 8'h4E) || (b == 8'h6E) || (b == 8'h49);
  endfunction

  function automatic opKind_e decodeOne(input logic [7:0] b);
    opKind_e k;
    k = OP_NOP;
    unique case (b)
      8'h5A: k = OP_LDAM;
      8'h59: k = OP_STAM;
      8'h7D: k = OP_STAMD;
      8'h7F: k = OP_STAMI;
      8'h65: k = OP_LDAX;
      8'h67: k = OP_LDAXI;
      8'h76: k = OP_THA;
      8'h74: k = OP_TLA;
      8'h50: k = OP_RLCA;
      8'h51: k = OP_RRCA;
      8'h70: k = OP_ADCAM;
      8'h71: k = OP_ADDAM;
      8'h5C: k = OP_DECA;
      8'h7C: k = OP_DECL;
      8'h5D: k = OP_DECM;
      8'h5E: k = OP_INCA;
      default: begin
        unique case (b[7:4])
          4'hD:    k = OP_LDIA;
          4'h9:    k = OP_LDH;
          4'h8:    k = OP_LDL;
          4'hA:    k = OP_STDMI;
          default: k = OP_NOP;
        endcase
      end
    endcase
    return k;
  endfunction

  function automatic opKind_e decodeTwo(input logic [7:0] p, input logic [7:0] b);
    opKind_e k;
    k = OP_NOP;
    unique case (p)
      8'h6A: k = OP_LDA;
      8'h69: k = OP_STA;
      8'h48: k = OP_STD;
      8'h4E: k = OP_LDHL;
      8'h49: k = OP_ADDY;
      8'h6E: begin
        unique case (b[7:4])
          4'h5:    k = OP_ADDA;
          4'h9:    k = OP_ADDH;
          4'h1:    k = OP_ADDL;
          4'hD:    k = OP_ADDM;
          default: k = OP_NOP;
        endcase
      end
      default: k = OP_NOP;
    endcase
    return k;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      prefix  <= 8'h00;
    end else if (instrValid) begin
      if (pending) begin
        pending <= 1'b0;
      end else if (isPrefix(instrByte)) begin
        pending <= 1'b1;
        prefix  <= instrByte;
      end
    end
  end

  always_comb begin
    strb      = '0;
    strb.op   = OP_NOP;
    if (instrValid) begin
      if (pending) begin
        strb.fire = 1'b1;
        strb.op   = decodeTwo(prefix, instrByte);
        if (prefix == 8'h48 || prefix == 8'h49) begin
          strb.imm  = instrByte[7:4];
          strb.addr = {4'h0, instrByte[3:0]};
        end else begin
          strb.imm  = instrByte[3:0];
          strb.addr = instrByte;
        end
      end else if (!isPrefix(instrByte)) begin
        strb.fire = 1'b1;
        strb.op   = decodeOne(instrByte);
        strb.imm  = instrByte[3:0];
      end
    end
  end
endmodule

// File: rtl/nib_dp.sv
module nib_dp
  import nib_pkg::*;
#(
  parameter int DP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [7:0]        tableData,
  output logic [DP_W-1:0]   dp,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] hr,
  output logic [DATA_W-1:0] lr,
  output logic              cf,
  output logic              zf,
  output logic              sf
);
  localparam int RAM_DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [RAM_DEPTH];

  logic [DATA_W-1:0] accN, hrN, lrN;
  logic              cN, zN, sN;
  logic [DP_W-1:0]   dpN;
  logic              ramWe;
  logic [ADDR_W-1:0] ramWa, hlAddr;
  logic [DATA_W-1:0] ramWd, memHl, memX, memEven, memOdd;
  logic [DATA_W:0]   sum;

  function automatic logic [DATA_W:0] add5(input logic [DATA_W-1:0] a,
                                           input logic [DATA_W-1:0] b,
                                           input logic cin);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  endfunction

  assign hlAddr  = {hr, lr};
  assign memHl   = ram[hlAddr];
  assign memX    = ram[strb.addr];
  assign memEven = ram[{strb.addr[ADDR_W-1:1], 1'b0}];
  assign memOdd  = ram[{strb.addr[ADDR_W-1:1], 1'b1}];

  always_comb begin
    accN  = acc; hrN = hr; lrN = lr;
    cN    = cf;  zN  = zf; sN  = sf;
    dpN   = dp;
    ramWe = 1'b0;
    ramWa = hlAddr;
    ramWd = acc;
    sum   = '0;
    if (strb.fire) begin
      unique case (strb.op)
        OP_LDIA:  begin accN = strb.imm; zN = (strb.imm == '0); end
        OP_LDH:   hrN = strb.imm;
        OP_LDL:   lrN = strb.imm;
        OP_LDA:   begin accN = memX; zN = (memX == '0); end
        OP_STA:   begin ramWe = 1'b1; ramWa = strb.addr; end
        OP_LDAM:  begin accN = memHl; zN = (memHl == '0); end
        OP_STAM:  ramWe = 1'b1;
        OP_STAMI: begin ramWe = 1'b1; lrN = lr + 4'd1; end
        OP_STAMD: begin ramWe = 1'b1; lrN = lr - 4'd1; end
        OP_STDMI: begin ramWe = 1'b1; ramWd = strb.imm; lrN = lr + 4'd1; end
        OP_STD:   begin ramWe = 1'b1; ramWa = strb.addr; ramWd = strb.imm; end
        OP_LDHL:  begin lrN = memEven; hrN = memOdd; end
        OP_LDAX:  begin accN = tableData[3:0]; zN = (tableData[3:0] == '0); end
        OP_LDAXI: begin
          accN = tableData[7:4]; zN = (tableData[7:4] == '0);
          dpN  = dp + 1'b1;
        end
        OP_THA:   begin accN = hr; zN = (hr == '0); end
        OP_TLA:   begin accN = lr; zN = (lr == '0); end
        OP_RLCA:  begin
          accN = {acc[2:0], cf}; cN = acc[3]; zN = ({acc[2:0], cf} == '0);
        end
        OP_RRCA:  begin
          accN = {cf, acc[3:1]}; cN = acc[0]; zN = ({cf, acc[3:1]} == '0);
        end
        OP_ADCAM, OP_ADDAM, OP_ADDA, OP_INCA, OP_DECA: begin
          unique case (strb.op)
            OP_ADCAM: sum = add5(acc, memHl, cf);
            OP_ADDAM: sum = add5(acc, memHl, 1'b0);
            OP_ADDA:  sum = add5(acc, strb.imm, 1'b0);
            OP_INCA:  sum = add5(acc, 4'd1, 1'b0);
            default:  sum = add5(acc, 4'hF, 1'b0);
          endcase
          accN = sum[3:0]; cN = sum[4];
          zN   = (sum[3:0] == '0); sN = ~sum[4];
        end
        OP_ADDH, OP_DECL, OP_ADDL: begin
          unique case (strb.op)
            OP_ADDH: sum = add5(hr, strb.imm, 1'b0);
            OP_ADDL: sum = add5(lr, strb.imm, 1'b0);
            default: sum = add5(lr, 4'hF, 1'b0);
          endcase
          if (strb.op == OP_ADDH) hrN = sum[3:0];
          else                    lrN = sum[3:0];
          zN = (sum[3:0] == '0); sN = ~sum[4];
        end
        OP_ADDM, OP_DECM: begin
          sum   = add5(memHl, (strb.op == OP_ADDM) ? strb.imm : 4'hF, 1'b0);
          ramWe = 1'b1; ramWd = sum[3:0];
          zN    = (sum[3:0] == '0); sN = ~sum[4];
        end
        OP_ADDY:  begin
          sum   = add5(memX, strb.imm, 1'b0);
          ramWe = 1'b1; ramWa = strb.addr; ramWd = sum[3:0];
          zN    = (sum[3:0] == '0); sN = ~sum[4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0; hr <= '0; lr <= '0;
      cf  <= 1'b0; zf <= 1'b0; sf <= 1'b0;
      dp  <= '0;
    end else begin
      acc <= accN; hr <= hrN; lr <= lrN;
      cf  <= cN;   zf <= zN;  sf <= sN;
      dp  <= dpN;
    end
  end

  always_ff @(posedge clk) begin
    if (ramWe) ram[ramWa] <= ramWd;
  end
endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_pkg::*;
#(
  parameter int DP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrValid,
  input  logic [7:0]      instrByte,
  input  logic [7:0]      tableData,
  output logic [DP_W-1:0] tableAddr,
  output logic [3:0]      acc,
  output logic [3:0]      ptrHi,
  output logic [3:0]      ptrLo,
  output logic            carry,
  output logic            zero,
  output logic            status
);
  ctrlStrobe_t strb;

  nib_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .instrByte(instrByte), .strb(strb)
  );

  nib_dp #(.DP_W(DP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tableData(tableData),
    .dp(tableAddr), .acc(acc), .hr(ptrHi), .lr(ptrLo),
    .cf(carry), .zf(zero), .sf(status)
  );
endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk
  import nib_pkg::*;
#(
  parameter int DP_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input ctrlStrobe_t     strb,
  input logic [DP_W-1:0] tableAddr,
  input logic [3:0]      acc,
  input logic [3:0]      ptrHi,
  input logic [3:0]      ptrLo,
  input logic            carry,
  input logic            zero,
  input logic            status
);
  AST_LDIA_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.op == OP_LDIA) |=> (acc == $past(strb.imm)) && (zero == (acc == 4'd0))); // R1
  AST_STAMI_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.op == OP_STAMI) |=> (ptrLo == $past(ptrLo) + 4'd1) && $stable(ptrHi)); // R4
  AST_TABLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.op == OP_LDAXI) |=> (tableAddr == $past(tableAddr) + 1'b1)); // R6
  AST_THA_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.op == OP_THA) |=> (acc == $past(ptrHi))); // R7
  AST_ADD_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.op == OP_ADDA) |=> (status == !carry)); // R9
  AST_DECL_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.op == OP_DECL) |=> (ptrLo == $past(ptrLo) - 4'd1) && (status == ($past(ptrLo) == 4'd0))); // R11
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.fire || strb.op == OP_NOP) |=> $stable(acc) && $stable(ptrHi) && $stable(ptrLo)
      && $stable(carry) && $stable(zero) && $stable(status) && $stable(tableAddr)); // R12
endmodule

bind nib_core nib_core_chk #(.DP_W(DP_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .tableAddr(tableAddr), .acc(acc),
  .ptrHi(ptrHi), .ptrLo(ptrLo), .carry(carry), .zero(zero), .status(status)
);

// File: tb/nib_core_tb.sv
module nib_core_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instrValid = 1'b0;
  logic [7:0] instrByte = 8'h00;
  logic [7:0] tableData;
  logic [7:0] tableAddr;
  logic [3:0] acc, ptrHi, ptrLo;
  logic       carry, zero, status;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [3:0] mAcc, mHr, mLr;
  logic       mC, mZ, mS;
  logic [7:0] mDp;
  logic [3:0] mRam [256];

  always #4 clk = ~clk;

  function automatic logic [7:0] tbl(input logic [7:0] a);
    return (a * 8'd37) + 8'd11;
  endfunction
  assign tableData = tbl(tableAddr);

  nib_core #(.DP_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrByte(instrByte),
    .tableData(tableData), .tableAddr(tableAddr), .acc(acc), .ptrHi(ptrHi),
    .ptrLo(ptrLo), .carry(carry), .zero(zero), .status(status)
  );

  function automatic bit twoByte(input logic [7:0] b);
    return b inside {8'h6A, 8'h69, 8'h48, 8'h4E, 8'h6E, 8'h49};
  endfunction

  function automatic string tagOf(input logic [7:0] b0, input logic [7:0] b1);
    casez (b0)
      8'b1101_????, 8'b1001_????, 8'b1000_????: return "R1";
      8'h6A, 8'h69: return "R2";
      8'h5A, 8'h59: return "R3";
      8'h7D, 8'h7F, 8'b1010_????: return "R4";
      8'h48, 8'h4E: return "R5";
      8'h65, 8'h67: return "R6";
      8'h76, 8'h74: return "R7";
      8'h50, 8'h51: return "R8";
      8'h70, 8'h71, 8'h5E: return "R9";
      8'h6E: return (b1[7:4] == 4'h5) ? "R9" :
                    (b1[7:4] inside {4'h9, 4'h1, 4'hD}) ? "R10" : "R12";
      8'h49: return "R10";
      8'h5C, 8'h7C, 8'h5D: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic model(input logic [7:0] b0, input logic [7:0] b1);
    logic [4:0] t;
    logic [7:0] hl;
    hl = {mHr, mLr};
    casez (b0)
      8'b1101_????: begin mAcc = b0[3:0]; mZ = (mAcc == 0); end
      8'b1001_????: mHr = b0[3:0];
      8'b1000_????: mLr = b0[3:0];
      8'b1010_????: begin mRam[hl] = b0[3:0]; mLr = mLr + 1; end
      8'h6A: begin mAcc = mRam[b1]; mZ = (mAcc == 0); end
      8'h69: mRam[b1] = mAcc;
      8'h5A: begin mAcc = mRam[hl]; mZ = (mAcc == 0); end
      8'h59: mRam[hl] = mAcc;
      8'h7F: begin mRam[hl] = mAcc; mLr = mLr + 1; end
      8'h7D: begin mRam[hl] = mAcc; mLr = mLr - 1; end
      8'h48: mRam[{4'h0, b1[3:0]}] = b1[7:4];
      8'h4E: begin mLr = mRam[b1 & 8'hFE]; mHr = mRam[b1 | 8'h01]; end
      8'h65: begin mAcc = tbl(mDp) & 4'hF; mZ = (mAcc == 0); end
      8'h67: begin mAcc = tbl(mDp) >> 4; mZ = (mAcc == 0); mDp = mDp + 1; end
      8'h76: begin mAcc = mHr; mZ = (mAcc == 0); end
      8'h74: begin mAcc = mLr; mZ = (mAcc == 0); end
      8'h50: begin t = {mAcc, mC}; mC = t[4]; mAcc = t[3:0]; mZ = (mAcc == 0); end
      8'h51: begin t = {mC, mAcc}; mC = t[0]; mAcc = t[4:1]; mZ = (mAcc == 0); end
      8'h70, 8'h71, 8'h5E, 8'h5C: begin
        if (b0 == 8'h70)      t = mAcc + mRam[hl] + mC;
        else if (b0 == 8'h71) t = mAcc + mRam[hl];
        else if (b0 == 8'h5E) t = mAcc + 5'd1;
        else                  t = mAcc + 5'd15;
        mAcc = t[3:0]; mC = t[4]; mZ = (mAcc == 0); mS = !t[4];
      end
      8'h7C: begin t = mLr + 5'd15; mLr = t[3:0]; mZ = (mLr == 0); mS = !t[4]; end
      8'h5D: begin t = mRam[hl] + 5'd15; mRam[hl] = t[3:0]; mZ = (t[3:0] == 0); mS = !t[4]; end
      8'h49: begin
        t = mRam[{4'h0, b1[3:0]}] + b1[7:4];
        mRam[{4'h0, b1[3:0]}] = t[3:0]; mZ = (t[3:0] == 0); mS = !t[4];
      end
      8'h6E: begin
        case (b1[7:4])
          4'h5: begin t = mAcc + b1[3:0]; mAcc = t[3:0]; mC = t[4]; mZ = (t[3:0] == 0); mS = !t[4]; end
          4'h9: begin t = mHr + b1[3:0]; mHr = t[3:0]; mZ = (t[3:0] == 0); mS = !t[4]; end
          4'h1: begin t = mLr + b1[3:0]; mLr = t[3:0]; mZ = (t[3:0] == 0); mS = !t[4]; end
          4'hD: begin t = mRam[hl] + b1[3:0]; mRam[hl] = t[3:0]; mZ = (t[3:0] == 0); mS = !t[4]; end
          default: ;
        endcase
      end
      default: ;
    endcase
  endtask

  task automatic checkState(input string tag);
    nChecks++;
    if (acc !== mAcc || ptrHi !== mHr || ptrLo !== mLr || carry !== mC ||
        zero !== mZ || status !== mS || tableAddr !== mDp) begin
      nFail++;
      $display("FAIL %s actual acc=%h hi=%h lo=%h c=%b z=%b s=%b dp=%h expected acc=%h hi=%h lo=%h c=%b z=%b s=%b dp=%h",
               tag, acc, ptrHi, ptrLo, carry, zero, status, tableAddr,
               mAcc, mHr, mLr, mC, mZ, mS, mDp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    instrValid = 1'b1;
    instrByte  = b;
    @(negedge clk);
    instrValid = 1'b0;
    instrByte  = 8'hD7;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic exec(input logic [7:0] b0, input logic [7:0] b1, input int gap, input bit chk);
    sendByte(b0);
    if (twoByte(b0)) begin
      if (chk) checkState("R12");
      idle(gap);
      sendByte(b1);
      model(b0, b1);
    end else begin
      model(b0, 8'h00);
    end
    if (chk) checkState(tagOf(b0, b1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1;
    void'($urandom(32'h5EED_1234));
    mAcc = 0; mHr = 0; mLr = 0; mC = 0; mZ = 0; mS = 0; mDp = 0;
    for (int i = 0; i < 256; i++) mRam[i] = 0;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R13");

    for (int h = 0; h < 16; h++) begin
      exec({4'h9, h[3:0]}, 8'h00, 0, 1'b0);
      for (int l = 0; l < 16; l++) exec({4'hA, 4'(h * 5 + l * 3)}, 8'h00, 0, 1'b0);
    end
    checkState("R4");

    exec(8'h8F, 0, 0, 1); exec(8'h93, 0, 0, 1); exec(8'hD9, 0, 0, 1);
    exec(8'h7F, 0, 0, 1);
    exec(8'h7D, 0, 0, 1); exec(8'h7D, 0, 0, 1);
    exec(8'hD0, 0, 0, 1); exec(8'h5C, 0, 0, 1);
    exec(8'hDF, 0, 0, 1); exec(8'h5E, 0, 0, 1);
    exec(8'h80, 0, 0, 1); exec(8'h7C, 0, 0, 1);
    exec(8'hDF, 0, 0, 1); exec(8'h50, 0, 0, 1); exec(8'h51, 0, 0, 1);
    exec(8'h6A, 8'h37, 3, 1); exec(8'h69, 8'hC4, 2, 1);
    exec(8'h4E, 8'h25, 1, 1); exec(8'h76, 0, 0, 1); exec(8'h74, 0, 0, 1);
    exec(8'h65, 0, 0, 1); exec(8'h67, 0, 0, 1); exec(8'h67, 0, 0, 1);
    exec(8'hFF, 0, 0, 1); exec(8'h00, 0, 0, 1); exec(8'h6E, 8'h00, 1, 1);
    exec(8'h6E, 8'hFA, 0, 1); exec(8'h6E, 8'h5F, 0, 1); exec(8'h70, 0, 0, 1);
    idle(4);
    checkState("R12");

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r4;
      r4 = 4'($urandom);
      b1 = 8'($urandom);
      case ($urandom % 30)
        0:  b0 = {4'hD, r4};
        1:  b0 = {4'h9, r4};
        2:  b0 = {4'h8, r4};
        3:  b0 = 8'h6A;
        4:  b0 = 8'h69;
        5:  b0 = 8'h5A;
        6:  b0 = 8'h59;
        7:  b0 = 8'h7D;
        8:  b0 = 8'h7F;
        9:  b0 = {4'hA, r4};
        10: b0 = 8'h48;
        11: b0 = 8'h4E;
        12: b0 = 8'h65;
        13: b0 = 8'h67;
        14: b0 = 8'h76;
        15: b0 = 8'h74;
        16: b0 = 8'h50;
        17: b0 = 8'h51;
        18: b0 = 8'h70;
        19: b0 = 8'h71;
        20: begin b0 = 8'h6E; b1 = {4'h5, r4}; end
        21: begin b0 = 8'h6E; b1 = {4'h9, r4}; end
        22: begin b0 = 8'h6E; b1 = {4'h1, r4}; end
        23: begin b0 = 8'h6E; b1 = {4'hD, r4}; end
        24: b0 = 8'h49;
        25: b0 = 8'h5C;
        26: b0 = 8'h7C;
        27: b0 = 8'h5D;
        28: b0 = 8'h5E;
        default: b0 = 8'($urandom);
      endcase
      exec(b0, b1, int'($urandom % 3), 1'b1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule